// File: doc/BRIEF.md
# Dual-Channel Squelch and Activity Detector

This block sits between the comparators of a serial network attachment interface and the logic that decodes the line. It watches two differential pairs, receive and collision. Each pair arrives as three digitized levels: a strong-negative flag that is high while the pair is past the valid-signal threshold, a positive flag, and a data level. All three are sampled with a fast local clock. The block keeps a single squelch for both pairs. The squelch is closed after reset. A strong-negative excursion that lasts long enough on either pair opens it for both pairs. A positive excursion that lasts long enough on either pair marks end of frame and closes it again. While the squelch is open, the two activity flags are high and the data levels pass through to the gated outputs. While it is closed, the gated outputs stay low.

Every input level passes through a two-flop synchronizer before any width is counted. Both width thresholds are parameters given in sample-clock counts. With a 200 MHz sample clock, the default of more than 5 samples qualifies a negative pulse longer than 25 ns. The default of more than 32 samples detects a positive gap longer than 160 ns. The squelch changes state at most once per qualifying excursion.

Top module: `squelch_gate`

## Requirements
- R1: After reset, rxActive, colActive, rxGated and colGated are all low.
- R2: A strong-negative flag held high on the receive pair for more than VALID_MIN consecutive samples opens the squelch. Both activity flags go high right after the (VALID_MIN+3)-th rising clock edge, counted from the first edge that samples the flag high.
- R3: A strong-negative pulse of VALID_MIN samples or fewer leaves the squelch closed. Its width count restarts from zero, so two short pulses separated by one low sample do not open it.
- R4: Activity on the positive flag or the data level alone, of any width, never opens the squelch.
- R5: A qualifying strong-negative pulse on the collision pair alone opens the squelch for both pairs, with the same latency as R2.
- R6: While the squelch is open, a positive flag held high on the receive pair for more than EOF_MIN samples closes it. Both activity flags fall right after the (EOF_MIN+3)-th edge of the excursion. A gap of EOF_MIN samples or fewer leaves the squelch open.
- R7: A positive excursion of more than EOF_MIN samples on the collision pair closes the squelch in the same way as R6.
- R8: While the squelch is open, each gated output equals its pair's data level delayed by two clock edges. While the squelch is closed, each gated output is low.
- R9: A strong-negative pulse has no effect while the squelch is already open. A single strong-negative pulse that is still high when end of frame closes the squelch does not reopen it.
- R10: rxActive and colActive are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (200 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| rxNegIn | input | 1 | Receive pair past the strong-negative threshold |
| rxPosIn | input | 1 | Receive pair positive |
| rxDataIn | input | 1 | Receive pair data level |
| colNegIn | input | 1 | Collision pair past the strong-negative threshold |
| colPosIn | input | 1 | Collision pair positive |
| colDataIn | input | 1 | Collision pair data level |
| rxActive | output | 1 | Squelch open, receive activity |
| colActive | output | 1 | Squelch open, collision activity |
| rxGated | output | 1 | Receive data after the squelch gate |
| colGated | output | 1 | Collision data after the squelch gate |

## Verification
Negative pulse widths are swept from 1 to 10 samples on each pair separately, and the activity flags are compared every cycle against the arithmetic opening edge. This separates a correct threshold from one that is off by one sample, and a shared squelch from one tied to a single pair. Positive gaps from 30 to 35 samples are swept on each pair after the squelch has opened, which places the end-of-frame edge exactly. Further patterns cover positive-only and data-only activity, two short pulses back to back, a negative pulse while the squelch is open, and a collision pulse that spans the closing. Together they expose a counter that is not cleared, an open squelch that retriggers, and a reopen on a stale pulse. Data gating is checked on both sides of a squelch transition.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_RX  = 0;
  localparam int CH_COL = 1;

  typedef struct packed {
    logic openSq;
    logic closeSq;
  } sqStrobe_t;
endpackage

// File: rtl/sq_sync.sv
module sq_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/sq_control.sv
module sq_control
  import sq_pkg::*;
(
  input  logic              squelchOpen,
  input  logic [NUM_CH-1:0] validNeg,
  input  logic [NUM_CH-1:0] longPos,
  output sqStrobe_t         strobe
);
  always_comb begin
    strobe = '0;
    if (!squelchOpen) strobe.openSq  = |validNeg;
    else              strobe.closeSq = |longPos;
  end
endmodule

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
#(
  parameter int VALID_MIN = 5,
  parameter int EOF_MIN   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] negS,
  input  logic [NUM_CH-1:0] posS,
  input  logic [NUM_CH-1:0] dataS,
  input  sqStrobe_t         strobe,
  output logic [NUM_CH-1:0] validNeg,
  output logic [NUM_CH-1:0] longPos,
  output logic              squelchOpen,
  output logic [NUM_CH-1:0] gated
);
  localparam int CNT_TOP = ((EOF_MIN > VALID_MIN) ? EOF_MIN : VALID_MIN) + 1;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam logic [CNT_W-1:0] NEG_HIT = CNT_W'(VALID_MIN);
  localparam logic [CNT_W-1:0] POS_HIT = CNT_W'(EOF_MIN);
  localparam logic [CNT_W-1:0] NEG_SAT = CNT_W'(VALID_MIN + 1);
  localparam logic [CNT_W-1:0] POS_SAT = CNT_W'(EOF_MIN + 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] negCnt;
    logic [CNT_W-1:0] posCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        negCnt <= '0;
        posCnt <= '0;
      end else begin
        if (!negS[ch])             negCnt <= '0;
        else if (negCnt != NEG_SAT) negCnt <= negCnt + 1'b1;
        if (!posS[ch])             posCnt <= '0;
        else if (posCnt != POS_SAT) posCnt <= posCnt + 1'b1;
      end
    end

    assign validNeg[ch] = negS[ch] && (negCnt == NEG_HIT);
    assign longPos[ch]  = posS[ch] && (posCnt == POS_HIT);

    // R3: a width count never runs past its saturation point
    assert_neg_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
      negCnt <= NEG_SAT);
    // R6: end-of-frame counter is bounded likewise
    assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
      posCnt <= POS_SAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               squelchOpen <= 1'b0;
    else if (strobe.openSq)  squelchOpen <= 1'b1;
    else if (strobe.closeSq) squelchOpen <= 1'b0;
  end

  assign gated = dataS & {NUM_CH{squelchOpen}};

  // R2: opening needs a qualified negative pulse on some pair
  assert_open_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(squelchOpen) |-> $past(|validNeg));
  // R6: closing needs a long positive excursion on some pair
  assert_close_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(squelchOpen) |-> $past(|longPos));
  // R4: without a qualified negative pulse a closed squelch stays closed
  assert_stay_closed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!squelchOpen && !(|validNeg)) |=> !squelchOpen);
  // R9: without end of frame an open squelch stays open
  assert_stay_open_R9: assert property (@(posedge clk) disable iff (!rstN)
    (squelchOpen && !(|longPos)) |=> squelchOpen);
endmodule

// File: rtl/squelch_gate.sv
module squelch_gate
  import sq_pkg::*;
#(
  parameter int VALID_MIN = 5,
  parameter int EOF_MIN   = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxNegIn,
  input  logic rxPosIn,
  input  logic rxDataIn,
  input  logic colNegIn,
  input  logic colPosIn,
  input  logic colDataIn,
  output logic rxActive,
  output logic colActive,
  output logic rxGated,
  output logic colGated
);
  localparam int SYNC_W = 3 * NUM_CH;

  logic [SYNC_W-1:0] rawBus;
  logic [SYNC_W-1:0] syncBus;
  logic [NUM_CH-1:0] negS, posS, dataS;
  logic [NUM_CH-1:0] validNeg, longPos, gated;
  logic              squelchOpen;
  sqStrobe_t         strobe;

  assign rawBus = {colDataIn, rxDataIn, colPosIn, rxPosIn, colNegIn, rxNegIn};

  sq_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawBus),
    .dout(syncBus)
  );

  assign negS  = syncBus[NUM_CH-1:0];
  assign posS  = syncBus[2*NUM_CH-1:NUM_CH];
  assign dataS = syncBus[3*NUM_CH-1:2*NUM_CH];

  sq_control u_control (
    .squelchOpen(squelchOpen),
    .validNeg   (validNeg),
    .longPos    (longPos),
    .strobe     (strobe)
  );

  sq_datapath #(.VALID_MIN(VALID_MIN), .EOF_MIN(EOF_MIN)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .negS       (negS),
    .posS       (posS),
    .dataS      (dataS),
    .strobe     (strobe),
    .validNeg   (validNeg),
    .longPos    (longPos),
    .squelchOpen(squelchOpen),
    .gated      (gated)
  );

  assign rxActive  = squelchOpen;
  assign colActive = squelchOpen;
  assign rxGated   = gated[CH_RX];
  assign colGated  = gated[CH_COL];

  // R8: gated data never shows while the activity flag is low
  assert_gate_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rxActive |-> !rxGated && !colGated);
endmodule

// File: tb/squelch_gate_bench.sv
`timescale 1ns/1ps
module squelch_gate_bench;
  localparam int VALID_MIN = 5;
  localparam int EOF_MIN   = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxNegIn = 0, rxPosIn = 0, rxDataIn = 0;
  logic colNegIn = 0, colPosIn = 0, colDataIn = 0;
  logic rxActive, colActive, rxGated, colGated;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  squelch_gate #(.VALID_MIN(VALID_MIN), .EOF_MIN(EOF_MIN)) u_squelch_gate (
    .clk(clk), .rstN(rstN),
    .rxNegIn(rxNegIn), .rxPosIn(rxPosIn), .rxDataIn(rxDataIn),
    .colNegIn(colNegIn), .colPosIn(colPosIn), .colDataIn(colDataIn),
    .rxActive(rxActive), .colActive(colActive),
    .rxGated(rxGated), .colGated(colGated)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stepCycle;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0;
    rxNegIn = 0; rxPosIn = 0; rxDataIn = 0;
    colNegIn = 0; colPosIn = 0; colDataIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setNeg(input int ch, input logic v);
    if (ch == 0) rxNegIn = v; else colNegIn = v;
  endtask

  task automatic setPos(input int ch, input logic v);
    if (ch == 0) rxPosIn = v; else colPosIn = v;
  endtask

  task automatic openNow;
    rxNegIn = 1'b1;
    repeat (VALID_MIN + 3) stepCycle();
    rxNegIn = 1'b0;
    repeat (4) stepCycle();
  endtask

  // Width sweep of a strong-negative pulse, checked every cycle
  task automatic negSweep(input int ch, input int n);
    doReset();
    setNeg(ch, 1'b1);
    for (int k = 1; k <= n + 6; k++) begin
      logic exp;
      stepCycle();
      if (k == n) setNeg(ch, 1'b0);
      exp = (n > VALID_MIN) && (k >= VALID_MIN + 3);
      if (ch == 1)            chk(rxActive, exp, "R5 collision-only start");
      else if (n > VALID_MIN) chk(rxActive, exp, "R2 valid pulse opens");
      else                    chk(rxActive, exp, "R3 short pulse rejected");
      chk(colActive, rxActive, "R10 flags equal");
    end
  endtask

  // Positive gap sweep after opening
  task automatic eofSweep(input int ch, input int m);
    doReset();
    openNow();
    chk(rxActive, 1'b1, "R2 open before gap");
    setPos(ch, 1'b1);
    for (int k = 1; k <= m + 6; k++) begin
      logic exp;
      stepCycle();
      if (k == m) setPos(ch, 1'b0);
      exp = !((m > EOF_MIN) && (k >= EOF_MIN + 3));
      if (ch == 0) chk(rxActive, exp, "R6 receive gap");
      else         chk(rxActive, exp, "R7 collision gap");
      chk(colActive, rxActive, "R10 flags equal");
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk(rxActive, 1'b0, "R1 rxActive");
    chk(colActive, 1'b0, "R1 colActive");
    chk(rxGated, 1'b0, "R1 rxGated");
    chk(colGated, 1'b0, "R1 colGated");

    for (int ch = 0; ch < 2; ch++)
      for (int n = 1; n <= 10; n++) negSweep(ch, n);

    for (int ch = 0; ch < 2; ch++)
      for (int m = EOF_MIN - 2; m <= EOF_MIN + 3; m++) eofSweep(ch, m);

    // R3 two short pulses with one low sample between
    doReset();
    rxNegIn = 1'b1;
    repeat (VALID_MIN) stepCycle();
    rxNegIn = 1'b0;
    stepCycle();
    rxNegIn = 1'b1;
    for (int k = 0; k < VALID_MIN + 6; k++) begin
      stepCycle();
      if (k == VALID_MIN - 1) rxNegIn = 1'b0;
      chk(rxActive, 1'b0, "R3 count restarts");
    end

    // R4 positive flags and data alone never open
    doReset();
    rxPosIn = 1'b1; colPosIn = 1'b1;
    for (int k = 0; k < 60; k++) begin
      stepCycle();
      rxDataIn = k[0]; colDataIn = ~k[0];
      chk(rxActive, 1'b0, "R4 positive only");
      chk(rxGated, 1'b0, "R8 closed gate rx");
      chk(colGated, 1'b0, "R8 closed gate col");
    end

    // R8 gating across opening
    doReset();
    rxDataIn = 1'b1; colDataIn = 1'b1;
    repeat (4) stepCycle();
    chk(rxGated, 1'b0, "R8 closed rx data");
    openNow();
    chk(rxGated, 1'b1, "R8 open rx data");
    chk(colGated, 1'b1, "R8 open col data");
    rxDataIn = 1'b0;
    stepCycle();
    chk(rxGated, 1'b1, "R8 delay edge 1");
    stepCycle();
    chk(rxGated, 1'b0, "R8 delay edge 2");
    chk(colGated, 1'b1, "R8 col unchanged");

    // R9 pulse while open has no effect
    rxNegIn = 1'b1;
    for (int k = 0; k < 12; k++) begin
      stepCycle();
      if (k == 9) rxNegIn = 1'b0;
      chk(rxActive, 1'b1, "R9 pulse while open");
    end

    // R9 pulse spanning the close does not reopen
    colNegIn = 1'b1;
    repeat (4) stepCycle();
    rxPosIn = 1'b1;
    for (int k = 1; k <= EOF_MIN + 20; k++) begin
      stepCycle();
      if (k == EOF_MIN + 2) rxPosIn = 1'b0;
      chk(rxActive, (k < EOF_MIN + 3), "R9 no reopen");
    end
    colNegIn = 1'b0;
    repeat (4) stepCycle();
    chk(colActive, 1'b0, "R9 stays closed");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule